// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This unit is the software-visible front of a raster display controller. A 32-bit bus with a word address reaches six registers: control, three timing words, status and sub-panel. The read-back values are not simply the stored bits. Some fields come back with constant bits forced high, the active-matrix flag appears at two positions, and the line width and height are kept in a minus-one encoding.

A separate fetch sequencer does the pixel and palette work. This unit tells it when to start and when to stop, using one-cycle pulses on the rising and falling edges of the controller enable bit. The sequencer reports back three events: frame done, palette loaded and synchronisation error. Each event sets a status flag.

One level-sensitive interrupt line combines the three flags. Frame done and palette loaded are each gated by their own enable. A synchronisation error raises the line with no mask. Toggling the enable bit also updates the flags: starting clears the completion flags, and stopping clears the error and marks the frame as done.

Top module: `lcdr_unit`

## Requirements
- R1: After reset the reads are as follows. Control reads 0xFE000C34. Timing 0 and timing 1 read 0x000003FF. Timing 2 reads 0xFC000000. Status and sub-panel read 0. The interrupt and all pulses are low.
- R2: Word 0 is the control register.
  - Bits 21:20 are the palette mode, bit 7 is active-matrix, bits 4:3 are the interrupt enables (bit 3 for frame done, bit 4 for palette loaded), bit 1 is monochrome and bit 0 is enable.
  - Other written bits are kept under the mask 0x01CFF300.
  - A read returns the fields in place, ORed with 0xFE000C34, with the active-matrix flag also copied to bit 23.
- R3: Words 1 and 2 (timing 0 and timing 1) store bits 31:10 as a field and bits 9:0 as a minus-one dimension. A read of word 1 additionally forces bits 3:0 to one.
- R4: Word 3 (timing 2) stores the whole word and reads back with bits 31:26 forced to one.
- R5: Word 5 (sub-panel) stores the written value ANDed with 0xA1FFFFFF.
- R6: Word 4 (status) is read-only. It shows palette loaded at bit 6, sync error at bit 2 and frame done at bit 0. Writes to it change nothing.
- R7: A sequencer event pulse in one cycle sets its flag. The flag is visible from the next cycle.
- R8: The interrupt is high exactly when one of these holds: frame done and enable bit 3 are both set; palette loaded and enable bit 4 are both set; or sync error is set.
- R9: A control write that changes enable from 0 to 1 clears frame done and palette loaded. It also makes start_req high for the one following cycle.
- R10: A control write that changes enable from 1 to 0 clears sync error. It sets frame done unless that same write carries palette mode 1. It also makes stop_req high for the one following cycle.
- R11: A control write that leaves enable unchanged produces no pulse and leaves the flags unchanged.
- R12: If a sequencer event falls in the same cycle as an enable edge that would clear its flag, the event wins and the flag ends up set.
- R13: Word addresses 6 and above read as 0 and ignore writes. Any access to them, read or write, makes bad_addr high for the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| bad_addr | output | 1 | One-cycle pulse after an unmapped access |
| evt_frame_done | input | 1 | Sequencer: frame finished |
| evt_palette_done | input | 1 | Sequencer: palette loaded |
| evt_sync_err | input | 1 | Sequencer: synchronisation error |
| start_req | output | 1 | One-cycle pulse after enable rises |
| stop_req | output | 1 | One-cycle pulse after enable falls |
| irq | output | 1 | Level interrupt |

## Verification
Two things can land on the status flags in the same cycle: an enable edge written over the bus, and a flag-setting event from the sequencer. The bench provokes this directly. It drives a frame-done event together with an enabling write, and a sync-error event together with a disabling write. It then reads the status word, which must show the flag set, and checks the interrupt level. The random phase mixes enable toggles with events on independent random draws. A bench model then applies the write effect first and the event second, and every status read and every interrupt sample is judged against that model.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUBP, SEL_NONE
  } reg_sel_e;

  localparam logic [WORD_W-1:0] CTRL_RD_SET = 32'hFE00_0C34;
  localparam logic [WORD_W-1:0] CTRL_KEEP   = 32'h01CF_F300;
  localparam logic [WORD_W-1:0] SUBP_KEEP   = 32'hA1FF_FFFF;
  localparam logic [WORD_W-1:0] TIM2_RD_SET = 32'hFC00_0000;
  localparam logic [WORD_W-1:0] TIM0_RD_SET = 32'h0000_000F;
  localparam logic [1:0]        PLM_NO_FD   = 2'd1;
endpackage

// File: rtl/lcdr_decode.sv
module lcdr_decode
  import lcdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    case (addr)
      ADDR_W'(0): sel = SEL_CTRL;
      ADDR_W'(1): sel = SEL_TIM0;
      ADDR_W'(2): sel = SEL_TIM1;
      ADDR_W'(3): sel = SEL_TIM2;
      ADDR_W'(4): sel = SEL_STAT;
      ADDR_W'(5): sel = SEL_SUBP;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/lcdr_cfg.sv
module lcdr_cfg
  import lcdr_pkg::*;
#(
  parameter int unsigned DIM_W = 10,
  localparam int unsigned TF_W = WORD_W - DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [1:0]        plm,
  output logic              tft,
  output logic [1:0]        ie,
  output logic              mono,
  output logic              en,
  output logic [WORD_W-1:0] other,
  output logic [TF_W-1:0]   t0,
  output logic [DIM_W-1:0]  w_m1,
  output logic [TF_W-1:0]   t1,
  output logic [DIM_W-1:0]  h_m1,
  output logic [WORD_W-1:0] t2,
  output logic [WORD_W-1:0] sub,
  output logic              en_rise,
  output logic              en_fall,
  output logic [1:0]        plm_new,
  output logic              start_req,
  output logic              stop_req
);
  logic              ctrl_wr;
  logic [1:0]        plm_d, ie_d;
  logic              tft_d, mono_d, en_d;
  logic [WORD_W-1:0] other_d, t2_d, sub_d;
  logic [TF_W-1:0]   t0_d, t1_d;
  logic [DIM_W-1:0]  w_d, h_d;

  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign en_rise = ctrl_wr && wdata[0] && !en;
  assign en_fall = ctrl_wr && !wdata[0] && en;
  assign plm_new = wdata[21:20];

  always_comb begin
    plm_d = plm; tft_d = tft; ie_d = ie; mono_d = mono; en_d = en;
    other_d = other; t0_d = t0; w_d = w_m1; t1_d = t1; h_d = h_m1;
    t2_d = t2; sub_d = sub;
    if (wr_en) begin
      case (sel)
        SEL_CTRL: begin
          plm_d   = wdata[21:20];
          tft_d   = wdata[7];
          ie_d    = wdata[4:3];
          mono_d  = wdata[1];
          en_d    = wdata[0];
          other_d = wdata & CTRL_KEEP;
        end
        SEL_TIM0: begin t0_d = wdata[WORD_W-1:DIM_W]; w_d = wdata[DIM_W-1:0]; end
        SEL_TIM1: begin t1_d = wdata[WORD_W-1:DIM_W]; h_d = wdata[DIM_W-1:0]; end
        SEL_TIM2: t2_d  = wdata;
        SEL_SUBP: sub_d = wdata & SUBP_KEEP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plm <= '0; tft <= 1'b0; ie <= '0; mono <= 1'b0; en <= 1'b0;
      other <= '0; t0 <= '0; w_m1 <= '1; t1 <= '0; h_m1 <= '1;
      t2 <= '0; sub <= '0; start_req <= 1'b0; stop_req <= 1'b0;
    end else begin
      if (wr_en) begin
        plm <= plm_d; tft <= tft_d; ie <= ie_d; mono <= mono_d; en <= en_d;
        other <= other_d; t0 <= t0_d; w_m1 <= w_d; t1 <= t1_d; h_m1 <= h_d;
        t2 <= t2_d; sub <= sub_d;
      end
      start_req <= en_rise;
      stop_req  <= en_fall;
    end
  end
endmodule

// File: rtl/lcdr_flags.sv
module lcdr_flags
  import lcdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic [1:0] plm_new,
  input  logic [1:0] ie,
  input  logic       evt_fd,
  input  logic       evt_pd,
  input  logic       evt_se,
  output logic       fd_q,
  output logic       pd_q,
  output logic       se_q,
  output logic       irq
);
  logic fd_d, pd_d, se_d, upd;

  always_comb begin
    fd_d = fd_q; pd_d = pd_q; se_d = se_q;
    if (en_rise) begin
      fd_d = 1'b0;
      pd_d = 1'b0;
    end
    if (en_fall) begin
      se_d = 1'b0;
      if (plm_new != PLM_NO_FD) fd_d = 1'b1;
    end
    if (evt_fd) fd_d = 1'b1;
    if (evt_pd) pd_d = 1'b1;
    if (evt_se) se_d = 1'b1;
  end

  assign upd = en_rise | en_fall | evt_fd | evt_pd | evt_se;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q <= 1'b0; pd_q <= 1'b0; se_q <= 1'b0;
    end else if (upd) begin
      fd_q <= fd_d; pd_q <= pd_d; se_q <= se_d;
    end
  end

  assign irq = (fd_q & ie[0]) | (pd_q & ie[1]) | se_q;
endmodule

// File: rtl/lcdr_unit.sv
module lcdr_unit
  import lcdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bad_addr,
  input  logic              evt_frame_done,
  input  logic              evt_palette_done,
  input  logic              evt_sync_err,
  output logic              start_req,
  output logic              stop_req,
  output logic              irq
);
  localparam int unsigned TF_W = WORD_W - DIM_W;

  reg_sel_e          sel;
  logic              wr_en, en_rise, en_fall, tft, mono, en, bad_d;
  logic              fd_q, pd_q, se_q;
  logic [1:0]        plm, ie, plm_new;
  logic [WORD_W-1:0] other, t2, sub;
  logic [TF_W-1:0]   t0, t1;
  logic [DIM_W-1:0]  w_m1, h_m1;

  assign wr_en = bus_valid && bus_we;

  lcdr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

  lcdr_cfg #(.DIM_W(DIM_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(bus_wdata),
    .plm(plm), .tft(tft), .ie(ie), .mono(mono), .en(en), .other(other),
    .t0(t0), .w_m1(w_m1), .t1(t1), .h_m1(h_m1), .t2(t2), .sub(sub),
    .en_rise(en_rise), .en_fall(en_fall), .plm_new(plm_new),
    .start_req(start_req), .stop_req(stop_req)
  );

  lcdr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en_rise(en_rise), .en_fall(en_fall),
    .plm_new(plm_new), .ie(ie), .evt_fd(evt_frame_done),
    .evt_pd(evt_palette_done), .evt_se(evt_sync_err),
    .fd_q(fd_q), .pd_q(pd_q), .se_q(se_q), .irq(irq)
  );

  always_comb begin
    case (sel)
      SEL_CTRL: bus_rdata = CTRL_RD_SET | other | (WORD_W'(tft) << 23) |
                            (WORD_W'(plm) << 20) | (WORD_W'(tft) << 7) |
                            (WORD_W'(ie) << 3) | (WORD_W'(mono) << 1) |
                            WORD_W'(en);
      SEL_TIM0: bus_rdata = {t0, w_m1} | TIM0_RD_SET;
      SEL_TIM1: bus_rdata = {t1, h_m1};
      SEL_TIM2: bus_rdata = t2 | TIM2_RD_SET;
      SEL_STAT: bus_rdata = (WORD_W'(pd_q) << 6) | (WORD_W'(se_q) << 2) |
                            WORD_W'(fd_q);
      SEL_SUBP: bus_rdata = sub;
      default:  bus_rdata = '0;
    endcase
  end

  assign bad_d = bus_valid && (sel == SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_addr <= 1'b0;
    else        bad_addr <= bad_d;
  end
endmodule

// File: rtl/lcdr_chk.sv
module lcdr_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bad_addr,
  input logic              evt_frame_done,
  input logic              evt_palette_done,
  input logic              evt_sync_err,
  input logic              start_req,
  input logic              stop_req,
  input logic              irq,
  input logic              fd_q,
  input logic              pd_q,
  input logic              se_q
);
  p_sync_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sync_err |=> irq);

  p_start_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(bus_valid && bus_we && bus_addr == '0 && bus_wdata[0]));

  p_rise_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !$past(evt_frame_done)) |-> !fd_q);

  p_stop_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(bus_valid && bus_we && bus_addr == '0 && !bus_wdata[0]));

  p_fall_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !$past(evt_sync_err)) |-> !se_q);

  p_status_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && bus_addr == ADDR_W'(4) &&
     !evt_frame_done && !evt_palette_done && !evt_sync_err)
    |=> $stable({fd_q, pd_q, se_q}));

  p_bad_src_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> $past(bus_valid && bus_addr > ADDR_W'(5)));
endmodule

bind lcdr_unit lcdr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bad_addr(bad_addr),
  .evt_frame_done(evt_frame_done), .evt_palette_done(evt_palette_done),
  .evt_sync_err(evt_sync_err), .start_req(start_req), .stop_req(stop_req),
  .irq(irq), .fd_q(fd_q), .pd_q(pd_q), .se_q(se_q)
);

// File: tb/lcdr_unit_tb.sv
module lcdr_unit_tb;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bad_addr, start_req, stop_req, irq;
  logic        evt_fd = 1'b0, evt_pd = 1'b0, evt_se = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  lcdr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bad_addr(bad_addr), .evt_frame_done(evt_fd), .evt_palette_done(evt_pd),
    .evt_sync_err(evt_se), .start_req(start_req), .stop_req(stop_req), .irq(irq)
  );

  // bench model
  logic [1:0]  m_plm, m_ie;
  logic        m_tft, m_mono, m_en, m_fd, m_pd, m_se;
  logic [31:0] m_other, m_t2, m_sub;
  logic [21:0] m_t0, m_t1;
  logic [9:0]  m_w, m_h;
  logic        x_start, x_stop, x_bad;

  task automatic model_reset();
    m_plm = 0; m_ie = 0; m_tft = 0; m_mono = 0; m_en = 0;
    m_fd = 0; m_pd = 0; m_se = 0; m_other = 0; m_t2 = 0; m_sub = 0;
    m_t0 = 0; m_t1 = 0; m_w = 10'h3FF; m_h = 10'h3FF;
    x_start = 0; x_stop = 0; x_bad = 0;
  endtask

  function automatic logic [31:0] model_read(logic [5:0] a);
    case (a)
      6'd0: return 32'hFE000C34 | m_other | (32'(m_tft) << 23) |
                   (32'(m_plm) << 20) | (32'(m_tft) << 7) | (32'(m_ie) << 3) |
                   (32'(m_mono) << 1) | 32'(m_en);
      6'd1: return {m_t0, m_w} | 32'hF;
      6'd2: return {m_t1, m_h};
      6'd3: return m_t2 | 32'hFC000000;
      6'd4: return (32'(m_pd) << 6) | (32'(m_se) << 2) | 32'(m_fd);
      6'd5: return m_sub;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [5:0] a);
    case (a)
      6'd0: return "R2";
      6'd1, 6'd2: return "R3";
      6'd3: return "R4";
      6'd4: return "R6";
      6'd5: return "R5";
      default: return "R13";
    endcase
  endfunction

  function automatic logic model_irq();
    return (m_fd & m_ie[0]) | (m_pd & m_ie[1]) | m_se;
  endfunction

  task automatic model_apply(bit v, bit we, logic [5:0] a, logic [31:0] d,
                             bit ef, bit ep, bit es);
    x_start = 0; x_stop = 0;
    x_bad = v && (a > 6'd5);
    if (v && we) begin
      case (a)
        6'd0: begin
          m_plm = d[21:20]; m_tft = d[7]; m_ie = d[4:3]; m_mono = d[1];
          m_other = d & 32'h01CFF300;
          if (d[0] && !m_en) begin
            m_fd = 0; m_pd = 0; x_start = 1;
          end else if (!d[0] && m_en) begin
            m_se = 0; if (m_plm != 2'd1) m_fd = 1; x_stop = 1;
          end
          m_en = d[0];
        end
        6'd1: begin m_t0 = d[31:10]; m_w = d[9:0]; end
        6'd2: begin m_t1 = d[31:10]; m_h = d[9:0]; end
        6'd3: m_t2 = d;
        6'd5: m_sub = d & 32'hA1FFFFFF;
        default: ;
      endcase
    end
    if (ef) m_fd = 1;
    if (ep) m_pd = 1;
    if (es) m_se = 1;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit we, logic [5:0] a, logic [31:0] d,
                      bit ef, bit ep, bit es, string tag = "");
    logic [31:0] e;
    @(negedge clk);
    bus_valid = v; bus_we = we; bus_addr = a; bus_wdata = d;
    evt_fd = ef; evt_pd = ep; evt_se = es;
    #1;
    if (v && !we) begin
      e = model_read(a);
      chk(bus_rdata === e, (tag == "") ? rtag(a) : tag, bus_rdata, e);
    end
    @(posedge clk);
    model_apply(v, we, a, d, ef, ep, es);
    #1;
    chk(start_req === x_start, "R9 start_req", 32'(start_req), 32'(x_start));
    chk(stop_req === x_stop, "R10 stop_req", 32'(stop_req), 32'(x_stop));
    chk(bad_addr === x_bad, "R13 bad_addr", 32'(bad_addr), 32'(x_bad));
    chk(irq === model_irq(), "R8 irq", 32'(irq), 32'(model_irq()));
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, string tag = "");
    step(1, 1, a, d, 0, 0, 0, tag);
  endtask
  task automatic rd(logic [5:0] a, string tag = "");
    step(1, 0, a, 32'h0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset view
    #1;
    chk(irq === 1'b0 && start_req === 1'b0 && stop_req === 1'b0, "R1 outputs",
        {29'b0, irq, start_req, stop_req}, 32'h0);
    for (int a = 0; a < 6; a++) rd(6'(a), "R1");

    // R2 control fields and read format
    wr(6'd0, 32'hFFFF_FFFE); rd(6'd0);
    wr(6'd0, 32'h0000_0000); rd(6'd0);
    // R3 / R4 / R5 formats
    wr(6'd1, 32'hABCD_1234); rd(6'd1);
    wr(6'd2, 32'h1234_5670); rd(6'd2);
    wr(6'd3, 32'h0123_4567); rd(6'd3);
    wr(6'd5, 32'hFFFF_FFFF); rd(6'd5);

    // R7 events and R8 sync irq with no enables
    step(0, 0, 6'd0, 0, 1, 1, 0); rd(6'd4, "R7");
    step(0, 0, 6'd0, 0, 0, 0, 1); rd(6'd4, "R7");
    // R6 status write ignored
    wr(6'd4, 32'h0000_0000); rd(6'd4, "R6");
    // R9 enable rise with interrupt enables on
    wr(6'd0, 32'h0000_0019); rd(6'd4, "R9");
    // R11 rewrite with enable unchanged
    step(0, 0, 6'd0, 0, 0, 1, 0);
    wr(6'd0, 32'h0000_0011); rd(6'd4, "R11");
    // R10 fall with palette mode 1: frame done stays clear, sync cleared
    step(0, 0, 6'd0, 0, 0, 0, 1);
    wr(6'd0, 32'h0010_0018); rd(6'd4, "R10");
    // R10 fall with palette mode 2: frame done set
    wr(6'd0, 32'h0000_0019); wr(6'd0, 32'h0020_0008); rd(6'd4, "R10");
    // R12 collisions: event with rise, sync event with fall
    step(1, 1, 6'd0, 32'h0000_0019, 1, 0, 0); rd(6'd4, "R12");
    step(1, 1, 6'd0, 32'h0010_0018, 0, 0, 1); rd(6'd4, "R12");
    // R13 unmapped
    wr(6'd0, 32'h0); rd(6'd4, "R13");
    wr(6'd6, 32'hFFFF_FFFF); wr(6'd63, 32'hFFFF_FFFF);
    rd(6'd40, "R13"); rd(6'd4, "R13"); rd(6'd0, "R13");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [5:0]  a;
      logic [31:0] d;
      bit v, we;
      v  = ($urandom % 8) != 0;
      we = $urandom % 2;
      a  = ($urandom % 5 == 0) ? 6'($urandom % 64) : 6'($urandom % 6);
      d  = $urandom;
      if (a == 6'd0 && ($urandom % 2 == 0)) d[0] = ~m_en;
      step(v, we, a, d, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 12) == 0);
    end

    @(negedge clk);
    bus_valid = 0; bus_we = 0; evt_fd = 0; evt_pd = 0; evt_se = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule